// File: doc/BRIEF.md
# Task-Based Page Translator

This block sits between an 8-bit processor with a 16-bit logical address bus and a larger physical memory. The logical space is cut into sixteen 4 KB pages. The top four address bits pick a page. A translation table replaces that page number with a physical page number, and the low twelve bits pass through unchanged. The table keeps a separate set of sixteen page entries for each of sixteen tasks. A task register chooses which set is used, so a context switch costs one register write and no table copy.

Software programs the table through write-only registers at the top of the logical map. Every entry write goes to the task that is active at that moment. The last 256 bytes of the logical space always decode to ROM, whatever the mapping says, so the reset and interrupt vectors stay reachable. A one-bit layout flag, loaded through the task register, is passed out to select between two arrangements of the ROM images.

Top module: `page_xlat_unit`

## Requirements
- R1: While reset is asserted and after it is released, `rom_layout` is 0 and the active task is task 0, so entries written before any task-register write are the ones used under task 0.
- R2: For a logical address below 0xFF00, `phys_addr` is {entry[active task][cpu_addr[15:12]], cpu_addr[11:0]} and `rom_sel` is 0. This is combinational in the address.
- R3: A write (`cpu_wr`=1) to address 0xFFF0+n stores `cpu_wdata[3:0]` into entry n of the active task. Translation uses the new entry from the next clock cycle on.
- R4: Bits [7:4] of the data in an entry write are ignored. Only bits [3:0] become the physical page number.
- R5: A write to 0xFF7F loads the active task from `cpu_wdata[3:0]`. From the next cycle on, translation uses that task's entries.
- R6: A write to 0xFF7F sets `rom_layout` to `cpu_wdata[5]` from the next cycle on. No other access changes `rom_layout`.
- R7: For logical addresses 0xFF00 to 0xFFFF, `rom_sel` is 1 and `phys_addr` is {all ones, cpu_addr[11:0]}, whatever the page 15 entry holds.
- R8: An entry write under one task leaves the entries of every other task unchanged.
- R9: Reads (`cpu_wr`=0) at 0xFF7F or 0xFFF0 to 0xFFFF change neither the table, the task nor `rom_layout`.
- R10: Writes to any other address, including 0xFF7E, 0xFFEF and RAM addresses, change neither the table, the task nor `rom_layout`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_addr | input | 16 | Logical address from the processor |
| cpu_wr | input | 1 | Write strobe, valid for one cycle per write |
| cpu_wdata | input | 8 | Write data |
| phys_addr | output | 16 | Physical address: page number and 12-bit offset |
| rom_sel | output | 1 | High for the ROM region pinned at the top 256 bytes |
| rom_layout | output | 1 | Selects the ROM image arrangement |

## Verification
The translation registers live inside logical page 15. An entry write for page 15 therefore changes the mapping of the very page that holds the write, while the same cycle must still decode as pinned ROM. The bench remaps page 15 with a write to 0xFFFF. In the next cycle it checks that 0xF800 follows the new entry and that 0xFFxx still returns the ROM address with `rom_sel` high. A task-register write that carries the layout bit is checked in the same way: the task and `rom_layout` change together on one edge, and both are judged in the following cycle.

// File: rtl/pxu_pkg.sv
package pxu_pkg;
  localparam int ADDR_W     = 16;
  localparam int DATA_W     = 8;
  localparam int PAGE_W     = 4;
  localparam int OFFS_W     = ADDR_W - PAGE_W;
  localparam int NPAGES     = 1 << PAGE_W;
  localparam int TASK_W     = 4;
  localparam int PPN_W      = 4;
  localparam int LAYOUT_BIT = 5;
  localparam int PIN_W      = 8;   // pinned ROM region: top 2**PIN_W bytes

  localparam logic [ADDR_W-1:0] TASK_REG_ADDR = 16'hFF7F;

  typedef logic [PAGE_W-1:0] page_t;
endpackage

// File: rtl/pxu_regs.sv
module pxu_regs
  import pxu_pkg::*;
#(
  parameter int TASK_W = pxu_pkg::TASK_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic              cpu_wr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic [TASK_W-1:0] task_q,
  output logic              layout_q,
  output logic              map_we,
  output page_t             map_page
);
  logic              task_hit;
  logic [TASK_W-1:0] task_d;
  logic              layout_d;

  // decode of the write-only register block
  always_comb begin
    task_hit = cpu_wr && (cpu_addr == TASK_REG_ADDR);
    map_we   = cpu_wr && (cpu_addr[ADDR_W-1:PAGE_W] == '1);
    map_page = cpu_addr[PAGE_W-1:0];
  end

  // next state
  always_comb begin
    task_d   = task_q;
    layout_d = layout_q;
    if (task_hit) begin
      task_d   = cpu_wdata[TASK_W-1:0];
      layout_d = cpu_wdata[LAYOUT_BIT];
    end
  end

  // state
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      task_q   <= '0;
      layout_q <= 1'b0;
    end else begin
      task_q   <= task_d;
      layout_q <= layout_d;
    end
  end
endmodule

// File: rtl/pxu_table.sv
module pxu_table
  import pxu_pkg::*;
#(
  parameter int TASK_W = pxu_pkg::TASK_W,
  parameter int PPN_W  = pxu_pkg::PPN_W
) (
  input  logic              clk,
  input  logic              we,
  input  logic [TASK_W-1:0] wr_task,
  input  page_t             wr_page,
  input  logic [PPN_W-1:0]  wr_ppn,
  input  logic [TASK_W-1:0] rd_task,
  input  page_t             rd_page,
  output logic [PPN_W-1:0]  rd_ppn
);
  localparam int NTASKS = 1 << TASK_W;

  // contents undefined after power-up; software loads them
  logic [PPN_W-1:0] ent_q [NTASKS][NPAGES];
  logic [PPN_W-1:0] row   [NPAGES];

  always_ff @(posedge clk) begin
    if (we) ent_q[wr_task][wr_page] <= wr_ppn;
  end

  // select the active task's row, then the page within it
  for (genvar p = 0; p < NPAGES; p++) begin : g_row
    assign row[p] = ent_q[rd_task][p];
  end

  assign rd_ppn = row[rd_page];
endmodule

// File: rtl/pxu_xlate.sv
module pxu_xlate
  import pxu_pkg::*;
#(
  parameter int PPN_W = pxu_pkg::PPN_W
) (
  input  logic                    [ADDR_W-1:0] cpu_addr,
  input  logic                    [PPN_W-1:0]  ppn,
  output logic [PPN_W+OFFS_W-1:0]              phys_addr,
  output logic                                 rom_sel
);
  logic pinned;

  always_comb begin
    pinned  = (cpu_addr[ADDR_W-1:PIN_W] == '1);
    rom_sel = pinned;
    if (pinned) phys_addr = {{PPN_W{1'b1}}, cpu_addr[OFFS_W-1:0]};
    else        phys_addr = {ppn, cpu_addr[OFFS_W-1:0]};
  end
endmodule

// File: rtl/page_xlat_unit.sv
module page_xlat_unit
  import pxu_pkg::*;
#(
  parameter int TASK_W = pxu_pkg::TASK_W,
  parameter int PPN_W  = pxu_pkg::PPN_W
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [ADDR_W-1:0]       cpu_addr,
  input  logic                    cpu_wr,
  input  logic [DATA_W-1:0]       cpu_wdata,
  output logic [PPN_W+OFFS_W-1:0] phys_addr,
  output logic                    rom_sel,
  output logic                    rom_layout
);
  logic [TASK_W-1:0] task_q;
  logic              map_we;
  page_t             map_page;
  logic [PPN_W-1:0]  cur_ppn;

  pxu_regs #(.TASK_W(TASK_W)) i_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .cpu_addr (cpu_addr),
    .cpu_wr   (cpu_wr),
    .cpu_wdata(cpu_wdata),
    .task_q   (task_q),
    .layout_q (rom_layout),
    .map_we   (map_we),
    .map_page (map_page)
  );

  pxu_table #(.TASK_W(TASK_W), .PPN_W(PPN_W)) i_table (
    .clk    (clk),
    .we     (map_we),
    .wr_task(task_q),
    .wr_page(map_page),
    .wr_ppn (cpu_wdata[PPN_W-1:0]),
    .rd_task(task_q),
    .rd_page(cpu_addr[ADDR_W-1:OFFS_W]),
    .rd_ppn (cur_ppn)
  );

  pxu_xlate #(.PPN_W(PPN_W)) i_xlate (
    .cpu_addr (cpu_addr),
    .ppn      (cur_ppn),
    .phys_addr(phys_addr),
    .rom_sel  (rom_sel)
  );
endmodule

// File: rtl/pxu_checker.sv
module pxu_checker
  import pxu_pkg::*;
#(
  parameter int TASK_W = pxu_pkg::TASK_W,
  parameter int PPN_W  = pxu_pkg::PPN_W
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic [ADDR_W-1:0]       cpu_addr,
  input logic                    cpu_wr,
  input logic [DATA_W-1:0]       cpu_wdata,
  input logic [PPN_W+OFFS_W-1:0] phys_addr,
  input logic                    rom_sel,
  input logic                    rom_layout
);
  logic pin_zone, task_wr, map_wr;
  assign pin_zone = (cpu_addr[ADDR_W-1:PIN_W] == '1);
  assign task_wr  = cpu_wr && (cpu_addr == TASK_REG_ADDR);
  assign map_wr   = cpu_wr && (cpu_addr[ADDR_W-1:PAGE_W] == '1);

  // R1
  always @(posedge clk) begin
    if (!rst_n) reset_layout_chk: assert (rom_layout == 1'b0);
  end

  // R2
  offset_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pin_zone |-> (!rom_sel && phys_addr[OFFS_W-1:0] == cpu_addr[OFFS_W-1:0]));

  // R7
  rom_pin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pin_zone |-> (rom_sel && phys_addr == {{PPN_W{1'b1}}, cpu_addr[OFFS_W-1:0]}));

  // R3
  map_update_chk: assert property (@(posedge clk) disable iff (!rst_n)
    map_wr |=> (rom_sel || cpu_wr ||
                cpu_addr[ADDR_W-1:OFFS_W] != $past(cpu_addr[PAGE_W-1:0]) ||
                phys_addr[PPN_W+OFFS_W-1:OFFS_W] == $past(cpu_wdata[PPN_W-1:0])));

  // R6
  layout_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    task_wr |=> (rom_layout == $past(cpu_wdata[LAYOUT_BIT])));

  // R9 R10
  layout_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !task_wr |=> $stable(rom_layout));
endmodule

bind page_xlat_unit pxu_checker #(.TASK_W(TASK_W), .PPN_W(PPN_W)) i_chk (.*);

// File: tb/test_page_xlat_unit.sv
`timescale 1ns/1ps
module test_page_xlat_unit;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] cpu_addr;
  logic        cpu_wr;
  logic [7:0]  cpu_wdata;
  logic [15:0] phys_addr;
  logic        rom_sel;
  logic        rom_layout;

  int n_chk = 0;
  int n_bad = 0;

  logic [3:0] mdl_map [16][16];
  logic [3:0] mdl_task;
  logic       mdl_layout;

  always #2.5 clk = ~clk;

  page_xlat_unit i_page_xlat_unit (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wr(cpu_wr),
    .cpu_wdata(cpu_wdata), .phys_addr(phys_addr), .rom_sel(rom_sel),
    .rom_layout(rom_layout)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic bus_write(logic [15:0] a, logic [7:0] d);
    @(negedge clk);
    cpu_addr = a; cpu_wdata = d; cpu_wr = 1'b1;
    if (a == 16'hFF7F) begin
      mdl_task = d[3:0]; mdl_layout = d[5];
    end else if (a[15:4] == 12'hFFF) begin
      mdl_map[mdl_task][a[3:0]] = d[3:0];
    end
    @(negedge clk);
    cpu_wr = 1'b0;
  endtask

  // probe one address in the current cycle against the model
  task automatic probe(string req, logic [15:0] a);
    logic [15:0] exp;
    cpu_wr = 1'b0; cpu_addr = a;
    #1;
    if (a[15:8] == 8'hFF) exp = {4'hF, a[11:0]};
    else                  exp = {mdl_map[mdl_task][a[15:12]], a[11:0]};
    check(req, {15'd0, phys_addr, rom_sel}, {15'd0, exp, (a[15:8] == 8'hFF)});
  endtask

  task automatic t_reset;
    check("R1 layout", 32'(rom_layout), 32'd0);
    bus_write(16'hFFF2, 8'h07);
    probe("R1 write before task load", 16'h2ABC);
    bus_write(16'hFF7F, 8'h00);
    probe("R1 task 0 at reset", 16'h2ABC);
  endtask

  task automatic t_fill;
    for (int p = 0; p < 16; p++) bus_write(16'hFFF0 + 16'(p), 8'(p ^ 4'hA));
    for (int p = 0; p < 15; p++) probe("R2 R3 task0 page", {4'(p), 12'h5A5});
    probe("R3 immediate update", 16'h3001);
  endtask

  task automatic t_upper_ignored;
    bus_write(16'hFFF1, 8'hF3);
    probe("R4 upper data bits", 16'h1FFF);
  endtask

  task automatic t_task_switch;
    bus_write(16'hFF7F, 8'h01);
    for (int p = 0; p < 16; p++) bus_write(16'hFFF0 + 16'(p), 8'(~p));
    for (int p = 0; p < 15; p++) probe("R5 task1 page", {4'(p), 12'h123});
    bus_write(16'hFF7F, 8'h00);
    probe("R8 task0 page 0 kept", 16'h0FED);
    probe("R8 task0 page 1 kept", 16'h1FED);
    probe("R8 task0 page 9 kept", 16'h9FED);
  endtask

  task automatic t_layout;
    bus_write(16'hFF7F, 8'h21);
    check("R6 layout set", 32'(rom_layout), 32'd1);
    probe("R5 task follows layout write", 16'h4444);
    bus_write(16'hFF7F, 8'hD0);
    check("R6 layout clear", 32'(rom_layout), 32'd0);
    probe("R5 back to task0", 16'h4444);
  endtask

  task automatic t_pinned;
    bus_write(16'hFFFF, 8'h02);
    probe("R2 page15 remapped", 16'hF123);
    probe("R7 FF00", 16'hFF00);
    probe("R7 FF23", 16'hFF23);
    probe("R7 FFFF", 16'hFFFF);
    bus_write(16'hFFFF, 8'h06);
    probe("R3 R7 page15 same cycle pair", 16'hF800);
    probe("R7 still rom", 16'hFF7F);
  endtask

  task automatic t_reads_ignored;
    @(negedge clk);
    cpu_wr = 1'b0; cpu_addr = 16'hFFF3; cpu_wdata = 8'h0C;
    @(negedge clk);
    cpu_addr = 16'hFF7F; cpu_wdata = 8'h2F;
    @(negedge clk);
    probe("R9 entry unchanged", 16'h3000);
    check("R9 layout unchanged", 32'(rom_layout), 32'd0);
  endtask

  task automatic t_other_writes;
    logic [3:0] keep;
    keep = mdl_map[mdl_task][3];
    bus_write(16'hFF7E, 8'h2F);
    bus_write(16'hFFEF, 8'h0C);
    bus_write(16'h3000, 8'h0C);
    mdl_map[mdl_task][3] = keep;
    probe("R10 entry unchanged", 16'h3456);
    probe("R10 task unchanged", 16'h5456);
    check("R10 layout unchanged", 32'(rom_layout), 32'd0);
  endtask

  initial begin
    #1000000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; cpu_addr = 16'h0000; cpu_wr = 1'b0; cpu_wdata = 8'h00;
    mdl_task = 4'h0; mdl_layout = 1'b0;
    for (int t = 0; t < 16; t++)
      for (int p = 0; p < 16; p++) mdl_map[t][p] = 4'h0;
    repeat (3) @(negedge clk);
    #1 check("R1 layout in reset", 32'(rom_layout), 32'd0);
    @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_fill();
    t_upper_ignored();
    t_task_switch();
    t_layout();
    t_pinned();
    t_reads_ignored();
    t_other_writes();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end
endmodule